// File: doc/BRIEF.md
# Mode-Controlled Bit-Slice ALU

This block is a purely combinational arithmetic and logic unit of configurable width, assembled from a row of identical one-bit cells. Two mode inputs pick one of three operations on the two operands: incrementing the first operand, subtracting the second operand from the first, or taking their bitwise AND. All cells see the same mode inputs. Each cell passes its carry to the next more-significant cell.

Every cell holds a full adder. One adder input is always the cell's bit of the first operand. A small selector, driven by both mode bits, supplies the other adder input: a constant zero, the inverted bit of the second operand, or the plain bit of the second operand. Both arithmetic operations feed a carry of one into the least-significant cell. An output selector, driven only by the high mode bit, passes either the adder sum or the AND of the two operand bits. The carry leaving the top cell is brought out in the arithmetic modes and forced to zero in the logic mode.

Top module: `bsalu_top`

## Requirements
- R1: With mode_f=0 and mode_g=0, result equals (opd_a + 1) modulo 2^W, where W is the operand width.
- R2: With mode_f=0 and mode_g=0, carry_out is 1 exactly when opd_a is all ones, which is also when result wraps to 0.
- R3: With mode_f=0 and mode_g=1, result equals (opd_a - opd_b) modulo 2^W.
- R4: With mode_f=0 and mode_g=1, carry_out is 1 exactly when opd_a >= opd_b, with both read as unsigned numbers.
- R5: With mode_f=1, result equals opd_a AND opd_b bit by bit, and mode_g has no effect on it.
- R6: With mode_f=1, carry_out is 0 for any operands and any mode_g.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | W | First operand. It is always one of the adder inputs. |
| opd_b | input | W | Second operand. |
| mode_f | input | 1 | High mode bit: 0 selects arithmetic, 1 selects bitwise AND. |
| mode_g | input | 1 | Low mode bit: with mode_f=0, 0 selects increment and 1 selects subtract. |
| result | output | W | Operation result. |
| carry_out | output | 1 | Carry from the most-significant cell in the arithmetic modes, 0 otherwise. |

## Verification
The block holds no register, so result and carry_out belong to the operands and mode that are present, with a latency of zero cycles. The bench changes the inputs just after a rising clock edge and reads both outputs at the next falling edge. The ripple chain has settled half a period after the change, and no new stimulus arrives before the read. A 4-bit instance is swept over every operand pair and every mode value, and an 8-bit instance is driven with directed corner cases and random pairs, all within the same cycle discipline.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [1:0] {
    OP_INC   = 2'b00,
    OP_SUB   = 2'b01,
    OP_AND_A = 2'b10,
    OP_AND_B = 2'b11
  } op_e;

  // Second adder input of one cell, chosen by the full mode pair.
  function automatic logic pick_addend(input op_e op, input logic b_bit);
    logic y;
    case (op)
      OP_INC:  y = 1'b0;
      OP_SUB:  y = ~b_bit;
      default: y = b_bit;
    endcase
    return y;
  endfunction

  // One-bit full add, returned as {carry, sum}.
  function automatic logic [1:0] add_bit(input logic x, input logic y, input logic ci);
    logic s;
    logic co;
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
    return {co, s};
  endfunction

endpackage

// File: rtl/bsalu_addend_sel.sv
module bsalu_addend_sel
  import bsalu_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       b_bit,
  output logic       addend
);
  op_e op;

  always_comb begin
    op     = op_e'(mode);
    addend = pick_addend(op, b_bit);
  end
endmodule

// File: rtl/bsalu_full_adder.sv
module bsalu_full_adder
  import bsalu_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic sum,
  output logic co,
  output logic both
);
  logic [1:0] pair;

  always_comb begin
    pair = add_bit(x, y, ci);
    sum  = pair[0];
    co   = pair[1];
    // The generate term x&y is shared with the logic operation.
    both = x & y;
  end
endmodule

// File: rtl/bsalu_cell.sv
module bsalu_cell (
  input  logic [1:0] mode,
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       ci,
  output logic       co,
  output logic       res
);
  logic addend;
  logic sum;
  logic both;

  bsalu_addend_sel u_sel (
    .mode   (mode),
    .b_bit  (b_bit),
    .addend (addend)
  );

  bsalu_full_adder u_fa (
    .x    (a_bit),
    .y    (addend),
    .ci   (ci),
    .sum  (sum),
    .co   (co),
    .both (both)
  );

  // Only the high mode bit steers the cell output.
  assign res = mode[1] ? both : sum;
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top #(
  parameter int W = 8
) (
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic         mode_f,
  input  logic         mode_g,
  output logic [W-1:0] result,
  output logic         carry_out
);
  localparam logic SEED_CARRY = 1'b1;

  logic [1:0] mode;
  logic [W:0] carry_c;

  assign mode       = {mode_f, mode_g};
  assign carry_c[0] = SEED_CARRY;

  for (genvar i = 0; i < W; i++) begin : g_cell
    bsalu_cell u_cell (
      .mode  (mode),
      .a_bit (opd_a[i]),
      .b_bit (opd_b[i]),
      .ci    (carry_c[i]),
      .co    (carry_c[i+1]),
      .res   (result[i])
    );
  end

  assign carry_out = carry_c[W] & ~mode_f;
endmodule

// File: rtl/bsalu_chk.sv
module bsalu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opd_a,
  input logic [W-1:0] opd_b,
  input logic         mode_f,
  input logic         mode_g,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic [W:0]   carry_c
);
  logic [W:0]   inc_full;
  logic [W-1:0] diff;
  logic         known;

  always_comb begin
    inc_full = {1'b0, opd_a} + {{W{1'b0}}, 1'b1};
    diff     = opd_a - opd_b;
    known    = !$isunknown({opd_a, opd_b, mode_f, mode_g, result, carry_out, carry_c});
    if (known && !mode_f && !mode_g) begin
      AST_INC_SUM: assert (result == inc_full[W-1:0]) else $error("inc sum"); // R1
      AST_INC_WRAP: assert (carry_out == (opd_a == {W{1'b1}})) else $error("inc carry"); // R2
    end
    if (known && !mode_f && mode_g) begin
      AST_SUB_DIFF: assert (result == diff) else $error("sub diff"); // R3
      AST_SUB_NOBORROW: assert (carry_out == (opd_a >= opd_b)) else $error("sub carry"); // R4
    end
    if (known && mode_f) begin
      AST_AND_BITS: assert (result == (opd_a & opd_b)) else $error("and bits"); // R5
      AST_AND_NOCARRY: assert (carry_out == 1'b0) else $error("and carry"); // R6
    end
  end
endmodule

bind bsalu_top bsalu_chk #(.W(W)) u_chk (
  .opd_a     (opd_a),
  .opd_b     (opd_b),
  .mode_f    (mode_f),
  .mode_g    (mode_g),
  .result    (result),
  .carry_out (carry_out),
  .carry_c   (carry_c)
);

// File: tb/sim_bsalu_top.sv
`timescale 1ns/1ps
module sim_bsalu_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0] a8, b8, r8;
  logic [3:0] a4, b4, r4;
  logic       mf, mg, c8, c4;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bsalu_top #(.W(8)) u0 (.opd_a(a8), .opd_b(b8), .mode_f(mf), .mode_g(mg),
                         .result(r8), .carry_out(c8));
  bsalu_top #(.W(4)) u1 (.opd_a(a4), .opd_b(b4), .mode_f(mf), .mode_g(mg),
                         .result(r4), .carry_out(c4));

  // Behavioural reference on integers.
  task automatic model(input int n, input int a, input int b, input int f, input int g,
                       output int res, output int cy);
    int top = (1 << n) - 1;
    if (f != 0) begin
      res = a & b; cy = 0;
    end else if (g == 0) begin
      res = (a == top) ? 0 : a + 1;
      cy  = (a == top) ? 1 : 0;
    end else begin
      res = (a >= b) ? a - b : a - b + (1 << n);
      cy  = (a >= b) ? 1 : 0;
    end
  endtask

  task automatic check_one(input int n, input int got_r, input int got_c,
                           input int a, input int b, input int f, input int g);
    int er, ec;
    string rt, ct;
    model(n, a, b, f, g, er, ec);
    if (f != 0) begin rt = "R5"; ct = "R6"; end
    else if (g == 0) begin rt = "R1"; ct = "R2"; end
    else begin rt = "R3"; ct = "R4"; end
    total++;
    if (got_r != er) begin
      bad++;
      $display("FAIL %s w=%0d a=%0d b=%0d f=%0d g=%0d result actual=%0d expected=%0d",
               rt, n, a, b, f, g, got_r, er);
    end
    total++;
    if (got_c != ec) begin
      bad++;
      $display("FAIL %s w=%0d a=%0d b=%0d f=%0d g=%0d carry actual=%0d expected=%0d",
               ct, n, a, b, f, g, got_c, ec);
    end
  endtask

  // Inputs change after a rising edge; outputs are read at the falling edge.
  task automatic apply(input int a, input int b, input int f, input int g);
    @(posedge clk);
    a8 = 8'(a); b8 = 8'(b); a4 = 4'(a); b4 = 4'(b);
    mf = f[0]; mg = g[0];
    @(negedge clk);
    check_one(8, int'(r8), int'(c8), a & 255, b & 255, f, g);
    check_one(4, int'(r4), int'(c4), a & 15, b & 15, f, g);
  endtask

  initial begin
    a8 = '0; b8 = '0; a4 = '0; b4 = '0; mf = 1'b0; mg = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Initial state: all-zero inputs give an increment of zero (R1, R2).
    @(negedge clk);
    check_one(8, int'(r8), int'(c8), 0, 0, 0, 0);
    check_one(4, int'(r4), int'(c4), 0, 0, 0, 0);
    // Full sweep at width 4 over every mode value (R1..R6 exercised).
    for (int f = 0; f < 2; f++)
      for (int g = 0; g < 2; g++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            apply(a, b, f, g);
    // Directed corners at width 8.
    apply(255, 0, 0, 0);    // R2 wrap to zero
    apply(254, 0, 0, 0);    // R2 no carry just below wrap
    apply(77, 77, 0, 1);    // R4 equal operands
    apply(0, 1, 0, 1);      // R3 underflow, R4 borrow
    apply(255, 255, 1, 0);  // R6 no carry in logic mode
    apply(170, 85, 1, 1);   // R5 disjoint bits, g set
    apply(170, 85, 1, 0);   // R5 same operands, g clear
    // Random pairs at width 8.
    for (int k = 0; k < 2000; k++)
      apply(int'($urandom_range(255)), int'($urandom_range(255)),
            int'($urandom_range(1)), int'($urandom_range(1)));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule